// File: doc/BRIEF.md
# I2C Four-Register Control Target

This block is an I2C target that gives a host access to a small bank of 8-bit control registers. It watches SCL and SDA through a short synchronizer and finds START, repeated START and STOP. It answers one fixed 7-bit device address. It pulls SDA low through an open-drain enable. The register contents also appear in parallel on an output bus, so the rest of the chip can read them directly.

A write transaction carries a register-address byte and then any number of data bytes. A read transaction returns bytes starting at an internal pointer. That pointer moves forward by one after every data byte in either direction and wraps at the top of the bank. It keeps its value between transactions. A read with no register address therefore continues from the location after the last one accessed. To read a chosen register, the host writes only the register address, then issues a repeated START and reads.

The bus interface is plain: the bit-level I2C handshake is the flow control, so there is no valid/ready pair at the block's edge.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, every register and the pointer are zero and `sda_oe` is 0, so SDA is released.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START clears the bit counter and begins a new device-address byte, even in the middle of a byte.
- R3: The first byte after START holds the device address `DEV_ADDR` in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). On a match the target drives ACK, meaning SDA is held low during the ninth clock. On a mismatch it gives no ACK and leaves the bus and the registers untouched until the next START.
- R4: In a write, the byte after the device address is the register address, and only its low log2(NREG) bits are used. It is acknowledged and loads the pointer. Each following data byte is acknowledged and written to the register at the pointer. The parallel output shows the new value from the ACK clock of that byte onward.
- R5: The pointer increments by one after every data byte, written or read, and wraps from NREG-1 to 0. A write burst longer than the bank therefore overwrites registers written earlier in the same burst.
- R6: The pointer keeps its value between transactions. A read that is not preceded by a register address returns the register at the pointer, which is the last accessed location plus one.
- R7: A write that carries only a register address, followed by a repeated START and a read, returns the named register first.
- R8: In a read, the target keeps sending successive registers while the host ACKs each byte. After a host NACK it releases SDA and waits for STOP or START.
- R9: The target changes `sda_oe` only while SCL is low. It samples SDA on the rising edge of SCL.
- R10: The register outputs change only through an acknowledged data byte of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_q | output | NREG*8 | Register contents; register k occupies bits 8k+7..8k |

## Verification
The bench keeps the default `NREG` of 4. A five-byte write burst therefore passes the top of the bank and overwrites a register it wrote earlier, and a three-byte read burst crosses the same wrap. `SYNC_STAGES` stays at 2 and each quarter of an SCL period lasts ten system clocks. That gap is wider than the synchronizer delay, so the bench can see a change of `sda_oe` in the SCL-low window. The device address is set to 2Ah, which leaves 55h free as a mismatching address for the ignore case.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } eng_state_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_REG,
    RX_DATA
  } rx_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // bus conditions: SDA moves while SCL stays high across both samples
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int NREG = 4,
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [PW-1:0]                       wr_addr,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0]      wr_data,
  input  logic [PW-1:0]                       rd_addr,
  output logic [i2c_tgt_pkg::BYTE_W-1:0]      rd_data,
  output logic [NREG*i2c_tgt_pkg::BYTE_W-1:0] q
);
  import i2c_tgt_pkg::*;

  logic [BYTE_W-1:0] mem [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[k] <= '0;
      else if (wr_en && (wr_addr == PW'(k)))      mem[k] <= wr_data;
    end
    assign q[k*BYTE_W +: BYTE_W] = mem[k];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_addr == PW'(k)) rd_data = mem[k];
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NREG     = 4,
  localparam int        PW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sda_s,
  input  logic                           scl_rise,
  input  logic                           scl_fall,
  input  logic                           start_det,
  input  logic                           stop_det,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0] rd_data,
  output logic [PW-1:0]                  rd_addr,
  output logic                           wr_en,
  output logic [PW-1:0]                  wr_addr,
  output logic [i2c_tgt_pkg::BYTE_W-1:0] wr_data,
  output logic                           sda_oe
);
  import i2c_tgt_pkg::*;

  eng_state_t        state;
  rx_kind_t          kind;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [PW-1:0]     ptr;
  logic              rw, mack;
  logic [PW-1:0]     ptr_nxt;
  logic              byte_end;

  assign ptr_nxt  = (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;
  assign byte_end = scl_fall && (cnt == 4'd8);
  assign wr_en    = (state == ST_RX) && !start_det && !stop_det &&
                    byte_end && (kind == RX_DATA);
  assign wr_addr  = ptr;
  assign wr_data  = sh;
  assign rd_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= RX_DEV;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_RX;
      kind   <= RX_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            unique case (kind)
              RX_DEV: begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end else begin
                  state  <= ST_SKIP;
                end
              end
              RX_REG: begin
                ptr    <= sh[PW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
              default: begin
                ptr    <= ptr_nxt;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (kind == RX_DEV && rw) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr    <= ptr_nxt;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
              kind   <= (kind == RX_DEV) ? RX_REG : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr    <= ptr_nxt;
              cnt    <= '0;
              state  <= ST_TX;
            end else begin
              state  <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NREG        = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_q
);
  import i2c_tgt_pkg::*;

  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PW-1:0]     wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  i2c_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .q(reg_q)
  );
endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker #(
  parameter int NREG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic              sda_oe,
  input logic [NREG*8-1:0] reg_q
);
  // R9: the SDA drive moves only in the SCL-low phase
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R2: a START releases the line
  a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R8: a STOP releases the line
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4: every register write goes with an ACK drive
  a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R10: outputs hold unless a write strobe was given
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));
endmodule

bind i2c_regbank_target i2c_regbank_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .wr_en(wr_en), .sda_oe(sda_oe), .reg_q(reg_q)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;
  localparam logic [7:0] DW_B = {DEV, 1'b0};
  localparam logic [7:0] DR_B = {DEV, 1'b1};
  // entries: {register index, data}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h11}, {2'd1, 8'h22}, {2'd2, 8'h33},
    {2'd3, 8'h44}, {2'd2, 8'h5A}, {2'd0, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [31:0] reg_q;
  int nchk = 0, nerr = 0, r9_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_target #(.DEV_ADDR(DEV), .NREG(4), .SYNC_STAGES(2)) i_i2c_regbank_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  // R9 monitor: any change of the drive while SCL is high
  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n && sda_oe !== prev_oe && scl) r9_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; wq(Q); scl = 1; wq(Q); ack = !sda_line; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1; wq(Q); b[i] = sda_line; wq(Q); scl = 0;
    end
    sda_m = !host_ack; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic a1, a2, a3;
    logic [7:0] rd;
    logic [31:0] snap;
    wq(5);
    // R1: reset state
    chk(reg_q == 0, "R1", reg_q, 0);
    chk(sda_oe == 0, "R1", {31'd0, sda_oe}, 0);
    rst_n = 1; wq(5);

    // table walk: write one register, then a random read of it
    foreach (VEC[v]) begin
      bus_start(); put_byte(DW_B, a1); put_byte({6'd0, VEC[v][9:8]}, a2); put_byte(VEC[v][7:0], a3); bus_stop();
      chk(a1 && a2 && a3, "R3 R4 acks", {29'd0, a1, a2, a3}, 32'h7);
      chk(reg_q[VEC[v][9:8]*8 +: 8] == VEC[v][7:0], "R4", reg_q, {24'd0, VEC[v][7:0]});
      bus_start(); put_byte(DW_B, a1); put_byte({6'd0, VEC[v][9:8]}, a2);
      bus_start(); put_byte(DR_B, a3); get_byte(1'b0, rd); bus_stop();
      chk(rd == VEC[v][7:0], "R7", {24'd0, rd}, {24'd0, VEC[v][7:0]});
    end
    // registers now 44,5A,22,A5 (3..0); pointer at 1

    // R6: current-address read continues at last+1
    bus_start(); put_byte(DR_B, a1); get_byte(1'b0, rd); bus_stop();
    chk(rd == 8'h22, "R6", {24'd0, rd}, 32'h22);

    // R5: five-byte burst from register 1 wraps and overwrites register 1
    bus_start(); put_byte(DW_B, a1); put_byte(8'h01, a1);
    put_byte(8'hC1, a1); put_byte(8'hC2, a1); put_byte(8'hC3, a1);
    put_byte(8'hC4, a1); put_byte(8'hC5, a2); bus_stop();
    chk(reg_q == 32'hC3C2C5C4, "R5", reg_q, 32'hC3C2C5C4);

    // R8/R5/R6: read burst from pointer 2 crosses the wrap
    snap = reg_q;
    bus_start(); put_byte(DR_B, a1);
    get_byte(1'b1, rd); chk(rd == 8'hC2, "R8", {24'd0, rd}, 32'hC2);
    get_byte(1'b1, rd); chk(rd == 8'hC3, "R8", {24'd0, rd}, 32'hC3);
    get_byte(1'b0, rd); chk(rd == 8'hC4, "R5 wrap read", {24'd0, rd}, 32'hC4);
    bus_stop(); wq(Q);
    chk(sda_oe == 0, "R8 release", {31'd0, sda_oe}, 0);
    chk(reg_q == snap, "R10", reg_q, snap);

    // R3: mismatching address is ignored
    bus_start(); put_byte({7'h55, 1'b0}, a1);
    chk(!a1, "R3 nack", {31'd0, a1}, 0);
    put_byte(8'h00, a2); put_byte(8'hFF, a3); bus_stop();
    chk(!a2 && !a3, "R3 ignore", {30'd0, a2, a3}, 0);
    chk(reg_q == snap, "R3 regs", reg_q, snap);

    // R2: START in the middle of a byte restarts address reception
    bus_start(); put_bit(1); put_bit(0); put_bit(1); put_bit(1);
    bus_start(); put_byte(DW_B, a1); put_byte(8'h03, a2); put_byte(8'h9E, a3); bus_stop();
    chk(a1 && a2 && a3, "R2 acks", {29'd0, a1, a2, a3}, 32'h7);
    chk(reg_q == 32'h9EC2C5C4, "R2", reg_q, 32'h9EC2C5C4);
    // pointer wrapped to 0 after the write to register 3
    bus_start(); put_byte(DR_B, a1); get_byte(1'b0, rd); bus_stop();
    chk(rd == 8'hC4, "R5 R6", {24'd0, rd}, 32'hC4);

    // R1: reset in mid-run clears registers and pointer
    rst_n = 0; wq(3);
    chk(reg_q == 0, "R1", reg_q, 0);
    rst_n = 1; wq(5);
    bus_start(); put_byte(DW_B, a1); put_byte(8'h02, a1); put_byte(8'h77, a1); bus_stop();
    bus_start(); put_byte(DW_B, a1); put_byte(8'h00, a1); put_byte(8'h66, a1); bus_stop();
    bus_start(); put_byte(DR_B, a1); get_byte(1'b0, rd); bus_stop();
    chk(rd == 8'h00, "R1 R6", {24'd0, rd}, 0);

    chk(r9_bad == 0, "R9", r9_bad, 0);
    finish_run();
  end
endmodule